// File: doc/BRIEF.md
# DMA Channel Teardown Sequencer

This block controls the shutdown and restart of one DMA channel, either transmit or receive. Software drives a small configuration register that holds an enable bit and a teardown bit. Setting the enable bit starts the channel. Setting the teardown bit asks the block to stop it. The channel run signal drops right away, and the block then waits for two things: the data path must report that it has drained, and the endpoint side must raise a teardown request. The endpoint may repeat that request until it is served.

Once both are present, the block writes an eight-word completion record to memory starting at a configured base address. Only the first word carries information: a fixed record type, the transfer direction, the DMA instance number and the channel number. The other seven words are zero. The block then pushes the base address onto the completion queue. After that the channel stays torn down until software clears both bits and then sets the enable bit again.

Top module: `tdc_chan_teardown`

## Requirements
- R1: After reset both configuration bits read 0, and `chan_run`, `mw_valid`, `cq_valid` and `torn_down` are all 0.
- R2: Writing enable=1, teardown=0 while idle makes `cfg_en_q` read 1 after the write edge and makes `chan_run` rise one clock edge later.
- R3: With the channel running, setting teardown drops `chan_run` at the next edge. No record word is written until `chan_idle` is high and an endpoint request (`ep_td_req`) has been seen since teardown began.
- R4: The record is exactly eight word writes at addresses base+4*i for i = 0..7, in rising order. Address and data are held stable while `mw_ready` is low.
- R5: Word 0 is built as follows: bits 31:27 = 19 (0x13), bit 16 = direction (0 transmit, 1 receive), bits 15:10 = DMA instance number, bits 5:0 = channel number, and bits 26:17 and 9:6 = 0.
- R6: Words 1 through 7 are all zero.
- R7: The cycle after the last word is accepted, `cq_valid` rises with `cq_addr` = base and is held until `cq_ready`. `torn_down` reads 1 from the edge that accepts the push.
- R8: Endpoint requests that arrive while the record is being written, while it is being pushed, or after teardown has completed produce no second record and no second push.
- R9: A teardown requested while the channel is disabled still produces exactly one record and one push.
- R10: While torn down, the channel does not run again, even if enable is written. Only after both bits read 0 does `torn_down` clear, one edge later. A later enable write then restarts the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_en_wr | input | 1 | Enable value to write |
| cfg_td_wr | input | 1 | Teardown value to write |
| cfg_en_q | output | 1 | Enable bit as stored |
| cfg_td_q | output | 1 | Teardown bit as stored |
| torn_down | output | 1 | Status: teardown complete, waiting for re-arm |
| chan_run | output | 1 | Channel may move data |
| chan_idle | input | 1 | Data path has reached a safe stopping point |
| ep_td_req | input | 1 | Endpoint-side teardown request |
| desc_base | input | ADDR_W | Byte address of the completion record |
| mw_valid | output | 1 | Memory write request |
| mw_addr | output | ADDR_W | Memory write byte address |
| mw_data | output | 32 | Memory write data |
| mw_ready | input | 1 | Memory write accepted |
| cq_valid | output | 1 | Completion queue push request |
| cq_addr | output | ADDR_W | Record address pushed to the queue |
| cq_ready | input | 1 | Completion queue push accepted |

## Verification
A configuration write shows up on the stored bits at the edge that samples it. The run and torn-down state follows one edge after that. Record writes begin one edge after the edge where `chan_idle` and an endpoint request are both present. Each accepted word advances the address at that same edge. The push appears one edge after the last word is accepted, and `torn_down` appears at the edge that accepts the push.

The bench runs a reference model that updates on the rising edge and compares every output at the following falling edge. Ready inputs change only after that comparison. The directed checks placed after each stimulus wait the number of edges given above.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_ACTIVE,
      S_TD_PEND,
      S_WR_DESC,
      S_PUSH_Q,
      S_TORN
   } tdc_state_e;

   localparam int unsigned TDC_WORD_W   = 32;
   localparam int unsigned TDC_ID_W     = 6;
   localparam logic [4:0]  TDC_REC_TYPE = 5'd19;

   function automatic logic [TDC_WORD_W-1:0] tdc_head_word(
      input logic                rx,
      input logic [TDC_ID_W-1:0] dma_id,
      input logic [TDC_ID_W-1:0] ch_id);
      logic [TDC_WORD_W-1:0] w;
      w        = '0;
      w[31:27] = TDC_REC_TYPE;
      w[16]    = rx;
      w[15:10] = dma_id;
      w[5:0]   = ch_id;
      return w;
   endfunction

endpackage

// File: rtl/tdc_cfg_reg.sv
module tdc_cfg_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic we,
   input  logic en_wr,
   input  logic td_wr,
   output logic en_q,
   output logic td_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
         td_q <= 1'b0;
      end else if (we) begin
         en_q <= en_wr;
         td_q <= td_wr;
      end
   end
endmodule

// File: rtl/tdc_seq.sv
module tdc_seq
   import tdc_pkg::*;
#(
   parameter int unsigned WORDS = 8,
   localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_en,
   input  logic             cfg_td,
   input  logic             chan_idle,
   input  logic             ep_req,
   input  logic             mw_ready,
   input  logic             cq_ready,
   output tdc_state_e       state,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

   logic ep_seen;
   logic go;

   assign go = (state == S_TD_PEND) && chan_idle && (ep_seen || ep_req);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ep_seen <= 1'b0;
      end else begin
         ep_seen <= (state == S_TD_PEND) && !go && (ep_seen || ep_req);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;
         idx   <= '0;
      end else begin
         case (state)
            S_IDLE: begin
               if (cfg_td)      state <= S_TD_PEND;
               else if (cfg_en) state <= S_ACTIVE;
            end
            S_ACTIVE: begin
               if (cfg_td)       state <= S_TD_PEND;
               else if (!cfg_en) state <= S_IDLE;
            end
            S_TD_PEND: begin
               if (go) begin
                  state <= S_WR_DESC;
                  idx   <= '0;
               end
            end
            S_WR_DESC: begin
               if (mw_ready) begin
                  if (idx == LAST) state <= S_PUSH_Q;
                  else             idx   <= idx + 1'b1;
               end
            end
            S_PUSH_Q: begin
               if (cq_ready) state <= S_TORN;
            end
            S_TORN: begin
               if (!cfg_en && !cfg_td) state <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/tdc_desc_fmt.sv
module tdc_desc_fmt
   import tdc_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned WORDS  = 8,
   parameter int unsigned DMA_ID = 0,
   parameter int unsigned CH_ID  = 0,
   parameter bit          IS_RX  = 1'b0,
   localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1,
   localparam int unsigned BYTE_SH = $clog2(TDC_WORD_W / 8)
) (
   input  tdc_state_e              state,
   input  logic [IDX_W-1:0]        idx,
   input  logic [ADDR_W-1:0]       base,
   output logic                    mw_valid,
   output logic [ADDR_W-1:0]       mw_addr,
   output logic [TDC_WORD_W-1:0]   mw_data,
   output logic                    cq_valid,
   output logic [ADDR_W-1:0]       cq_addr
);
   localparam logic [TDC_WORD_W-1:0] HEAD =
      tdc_head_word(IS_RX, TDC_ID_W'(DMA_ID), TDC_ID_W'(CH_ID));

   logic [TDC_WORD_W-1:0] words [WORDS];

   for (genvar i = 0; i < WORDS; i++) begin : g_word
      if (i == 0) begin : g_head
         assign words[i] = HEAD;
      end else begin : g_rsvd
         assign words[i] = '0;
      end
   end

   logic [IDX_W+BYTE_SH-1:0] offs;
   assign offs = {idx, {BYTE_SH{1'b0}}};

   assign mw_valid = (state == S_WR_DESC);
   assign mw_addr  = base + ADDR_W'(offs);
   assign mw_data  = words[idx];
   assign cq_valid = (state == S_PUSH_Q);
   assign cq_addr  = base;
endmodule

// File: rtl/tdc_chan_teardown.sv
module tdc_chan_teardown
   import tdc_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned WORDS  = 8,
   parameter int unsigned DMA_ID = 0,
   parameter int unsigned CH_ID  = 0,
   parameter bit          IS_RX  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_en_wr,
   input  logic              cfg_td_wr,
   output logic              cfg_en_q,
   output logic              cfg_td_q,
   output logic              torn_down,
   output logic              chan_run,
   input  logic              chan_idle,
   input  logic              ep_td_req,
   input  logic [ADDR_W-1:0] desc_base,
   output logic              mw_valid,
   output logic [ADDR_W-1:0] mw_addr,
   output logic [31:0]       mw_data,
   input  logic              mw_ready,
   output logic              cq_valid,
   output logic [ADDR_W-1:0] cq_addr,
   input  logic              cq_ready
);
   localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

   if (WORDS != 8) begin : g_bad_words
      $error("record length must be eight words");
   end
   if (DMA_ID >= (1 << TDC_ID_W)) begin : g_bad_dma
      $error("DMA_ID does not fit its field");
   end
   if (CH_ID >= (1 << TDC_ID_W)) begin : g_bad_ch
      $error("CH_ID does not fit its field");
   end
   if (ADDR_W < IDX_W + 2) begin : g_bad_aw
      $error("ADDR_W too narrow for record offsets");
   end

   tdc_state_e       state;
   logic [IDX_W-1:0] idx;

   tdc_cfg_reg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .en_wr (cfg_en_wr),
      .td_wr (cfg_td_wr),
      .en_q  (cfg_en_q),
      .td_q  (cfg_td_q)
   );

   tdc_seq #(.WORDS(WORDS)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_en    (cfg_en_q),
      .cfg_td    (cfg_td_q),
      .chan_idle (chan_idle),
      .ep_req    (ep_td_req),
      .mw_ready  (mw_ready),
      .cq_ready  (cq_ready),
      .state     (state),
      .idx       (idx)
   );

   tdc_desc_fmt #(
      .ADDR_W (ADDR_W),
      .WORDS  (WORDS),
      .DMA_ID (DMA_ID),
      .CH_ID  (CH_ID),
      .IS_RX  (IS_RX)
   ) u_fmt (
      .state    (state),
      .idx      (idx),
      .base     (desc_base),
      .mw_valid (mw_valid),
      .mw_addr  (mw_addr),
      .mw_data  (mw_data),
      .cq_valid (cq_valid),
      .cq_addr  (cq_addr)
   );

   assign chan_run  = (state == S_ACTIVE);
   assign torn_down = (state == S_TORN);
endmodule

// File: rtl/tdc_chan_teardown_chk.sv
module tdc_chan_teardown_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_td_q,
   input logic              torn_down,
   input logic              chan_run,
   input logic [ADDR_W-1:0] desc_base,
   input logic              mw_valid,
   input logic [ADDR_W-1:0] mw_addr,
   input logic [31:0]       mw_data,
   input logic              mw_ready,
   input logic              cq_valid,
   input logic [ADDR_W-1:0] cq_addr,
   input logic              cq_ready
);
   // R1
   run_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chan_run |-> !mw_valid && !cq_valid && !torn_down);

   // R3
   td_stops_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chan_run && cfg_td_q |=> !chan_run);

   // R4
   mw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr) && $stable(mw_data));

   // R5
   head_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mw_valid && (mw_addr == desc_base) |-> mw_data[31:27] == 5'd19);

   // R7
   cq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cq_valid && !cq_ready |=> cq_valid && $stable(cq_addr));

   // R7
   push_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cq_valid && cq_ready |=> torn_down);

   // R10
   torn_no_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      torn_down |=> !chan_run);
endmodule

bind tdc_chan_teardown tdc_chan_teardown_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_td_q  (cfg_td_q),
   .torn_down (torn_down),
   .chan_run  (chan_run),
   .desc_base (desc_base),
   .mw_valid  (mw_valid),
   .mw_addr   (mw_addr),
   .mw_data   (mw_data),
   .mw_ready  (mw_ready),
   .cq_valid  (cq_valid),
   .cq_addr   (cq_addr),
   .cq_ready  (cq_ready)
);

// File: tb/sim_tdc_chan_teardown.sv
module sim_tdc_chan_teardown;
   localparam int CLK_PERIOD = 10;
   localparam int AW    = 32;
   localparam int DMA   = 5;
   localparam int CH    = 11;
   localparam bit RX    = 1'b1;
   localparam logic [31:0] BASE = 32'h0000_1F00;
   localparam logic [31:0] HEAD = (32'd19 << 27) | (32'(RX) << 16) | (32'(DMA) << 10) | 32'(CH);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0, cfg_en_wr = 1'b0, cfg_td_wr = 1'b0;
   logic cfg_en_q, cfg_td_q, torn_down, chan_run;
   logic chan_idle = 1'b0, ep_td_req = 1'b0;
   logic [AW-1:0] desc_base = BASE;
   logic mw_valid, mw_ready = 1'b1;
   logic [AW-1:0] mw_addr;
   logic [31:0] mw_data;
   logic cq_valid, cq_ready = 1'b1;
   logic [AW-1:0] cq_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   tdc_chan_teardown #(.ADDR_W(AW), .WORDS(8), .DMA_ID(DMA), .CH_ID(CH), .IS_RX(RX)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en_wr(cfg_en_wr), .cfg_td_wr(cfg_td_wr),
      .cfg_en_q(cfg_en_q), .cfg_td_q(cfg_td_q), .torn_down(torn_down), .chan_run(chan_run),
      .chan_idle(chan_idle), .ep_td_req(ep_td_req), .desc_base(desc_base),
      .mw_valid(mw_valid), .mw_addr(mw_addr), .mw_data(mw_data), .mw_ready(mw_ready),
      .cq_valid(cq_valid), .cq_addr(cq_addr), .cq_ready(cq_ready));

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit started = 0, stall_en = 0;

   // reference model: 0 idle, 1 running, 2 waiting, 3 writing, 4 pushing, 5 torn down
   int m_ph = 0, m_idx = 0;
   bit m_en = 0, m_td = 0, m_ep = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_idx = 0; m_en = 0; m_td = 0; m_ep = 0;
      end else begin
         case (m_ph)
            0: if (m_td) m_ph = 2; else if (m_en) m_ph = 1;
            1: if (m_td) m_ph = 2; else if (!m_en) m_ph = 0;
            2: if (chan_idle && (m_ep || ep_td_req)) begin
                  m_ph = 3; m_idx = 0; m_ep = 0;
               end else if (ep_td_req) m_ep = 1;
            3: if (mw_ready) begin
                  if (m_idx == 7) m_ph = 4; else m_idx++;
               end
            4: if (cq_ready) m_ph = 5;
            default: if (!m_en && !m_td) m_ph = 0;
         endcase
         if (m_ph != 2) m_ep = 0;
         if (cfg_we) begin m_en = cfg_en_wr; m_td = cfg_td_wr; end
      end
   end

   logic [31:0] wa[$];
   logic [31:0] wd[$];
   int push_cnt = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic compare();
      chk("R1/R2/R10 cfg_en_q", 32'(cfg_en_q), 32'(m_en));
      chk("R1/R10 cfg_td_q", 32'(cfg_td_q), 32'(m_td));
      chk("R2/R3 chan_run", 32'(chan_run), 32'(m_ph == 1));
      chk("R3/R4 mw_valid", 32'(mw_valid), 32'(m_ph == 3));
      chk("R7 cq_valid", 32'(cq_valid), 32'(m_ph == 4));
      chk("R7/R10 torn_down", 32'(torn_down), 32'(m_ph == 5));
      if (m_ph == 3) begin
         chk("R4 mw_addr", mw_addr, BASE + 32'(4 * m_idx));
         chk("R5/R6 mw_data", mw_data, (m_idx == 0) ? HEAD : 32'h0);
      end
      if (m_ph == 4) chk("R7 cq_addr", cq_addr, BASE);
   endtask

   task automatic tick();
      if (mw_valid && mw_ready) begin wa.push_back(mw_addr); wd.push_back(mw_data); end
      if (cq_valid && cq_ready) push_cnt++;
      @(posedge clk);
      @(negedge clk);
      cyc++;
      if (cyc > 5000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected <5000 cycles", cyc);
         finish_run();
      end
      if (started) compare();
      mw_ready = stall_en ? ((cyc % 3) != 1) : 1'b1;
      cq_ready = stall_en ? ((cyc % 2) == 0) : 1'b1;
   endtask

   task automatic cfg_write(input bit en, input bit td);
      cfg_we = 1'b1; cfg_en_wr = en; cfg_td_wr = td;
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic wait_torn();
      for (int k = 0; k < 200 && !torn_down; k++) tick();
   endtask

   initial begin
      repeat (3) tick();
      started = 1;
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1 reset chan_run", 32'(chan_run), 0);
      chk("R1 reset mw_valid", 32'(mw_valid), 0);
      chk("R1 reset cq_valid", 32'(cq_valid), 0);
      chk("R1 reset torn_down", 32'(torn_down), 0);

      // R2 start
      cfg_write(1, 0);
      chk("R2 cfg_en_q after write", 32'(cfg_en_q), 1);
      tick();
      chk("R2 chan_run one edge later", 32'(chan_run), 1);

      // R3 teardown while running, data path busy
      chan_idle = 1'b0;
      cfg_write(1, 1);
      tick();
      chk("R3 chan_run dropped", 32'(chan_run), 0);
      ep_td_req = 1'b1; tick(); ep_td_req = 1'b0;
      for (int k = 0; k < 4; k++) begin
         tick();
         chk("R3 no write before idle", 32'(mw_valid), 0);
      end
      chan_idle = 1'b1;
      stall_en = 1;
      wait_torn();
      stall_en = 0;
      chk("R4 word count", 32'(wa.size()), 8);
      for (int i = 0; i < wa.size(); i++) begin
         chk("R4 word address", wa[i], BASE + 32'(4 * i));
         if (i == 0) chk("R5 head word", wd[i], HEAD);
         else        chk("R6 reserved word zero", wd[i], 0);
      end
      chk("R7 one push", 32'(push_cnt), 1);
      chk("R7 torn_down set", 32'(torn_down), 1);

      // R8 late endpoint requests; R10 re-arm order
      ep_td_req = 1'b1;
      repeat (5) tick();
      ep_td_req = 1'b0;
      cfg_write(1, 1);
      tick();
      chk("R10 enable with teardown set stays stopped", 32'(chan_run), 0);
      cfg_write(1, 0);
      tick();
      chk("R10 enable without clear stays stopped", 32'(chan_run), 0);
      chk("R10 still torn down", 32'(torn_down), 1);
      chk("R8 no duplicate push", 32'(push_cnt), 1);
      chk("R8 no duplicate words", 32'(wa.size()), 8);
      cfg_write(0, 0);
      tick();
      chk("R10 torn_down clears after both bits zero", 32'(torn_down), 0);
      cfg_write(1, 0);
      tick();
      chk("R10 restart after clear then set", 32'(chan_run), 1);

      // R9 teardown while disabled, endpoint request held throughout (R8)
      cfg_write(0, 0);
      tick();
      wa.delete(); wd.delete(); push_cnt = 0;
      chan_idle = 1'b1;
      ep_td_req = 1'b1;
      cfg_write(0, 1);
      wait_torn();
      repeat (5) tick();
      ep_td_req = 1'b0;
      tick();
      chk("R9 one push when disabled", 32'(push_cnt), 1);
      chk("R8 eight words despite held request", 32'(wa.size()), 8);
      if (wd.size() > 0) chk("R9 head word", wd[0], HEAD);
      chk("R9 torn_down", 32'(torn_down), 1);

      finish_run();
   end
endmodule